// File: doc/BRIEF.md
# Stretch-aware I2C SCL timing generator

This block produces the serial clock of an I2C master as a pull-low enable. Each clock period is made of a low phase and a high phase whose lengths come from two programmable 9-bit counts, counted on a prescaled tick that runs at either the module clock or half of it. The low phase is counted from the cycle in which the block starts pulling the line low. The programmed low count therefore has to cover both the minimum low time and the fall time.

The high phase is not counted from the release. It starts only once the synchronised line input reads high. Slow rise times and a slave that stretches the clock make the period longer instead of eating into the high time. The high count also fixes the START hold time, so it must include the SDA fall time at START. A suitable count for either phase is round(count_clock_kHz × (t_phase + tf) / 10000), with times in tenths of a microsecond and tf taken as 0.3 µs. At 100 kHz, t_phase is 4.7 µs for the low phase and 4.0 µs for the high phase. At 400 kHz it is 1.3 µs and 0.6 µs.

A byte engine drives the block. It raises `run` to start clocking and `hold` to freeze the line low at the end of a low phase. It receives a one-cycle strobe at each sample point and one at each shift point.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, and while `run` is low with no period in progress, `scl_pull` is 0 and both strobes are 0.
- R2: Each low phase keeps `scl_pull` at 1 for exactly Nlow × D consecutive cycles. The first of these cycles is the cycle that carries `fall_stb`. Nlow is the effective low count and D is the divide factor.
- R3: The span from a `rise_stb` cycle to the next `fall_stb` cycle is exactly Nhigh × D cycles, however long the line stayed low after release.
- R4: While the line input is held low by another device after release, `scl_pull` stays 0 and no strobe is produced.
- R5: Each count is 9 bits. The low count is {`cnt_ext[7]`, `low_lsb`} and the high count is {`cnt_ext[6]`, `high_lsb`}. Bits 5..0 of `cnt_ext` have no effect.
- R6: A count of 0 behaves as a count of 1.
- R7: `div_sel` = 0 gives D = 1 and `div_sel` = 1 gives D = 2; in general D = `div_sel` + 1.
- R8: If `hold` is 1 when a low phase ends, `scl_pull` stays 1 with no strobes until `hold` is 0. The line is released on the first clock edge that samples `hold` low.
- R9: `fall_stb` occurs only in a cycle with `scl_pull` = 1. `rise_stb` occurs only with `scl_pull` = 0. The two strobes never coincide.
- R10: When `run` falls, the current period completes its high phase. The line is then left released and no further strobes occur.
- R11: When `run` rises in idle, `scl_pull` and `fall_stb` both become 1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Request to keep generating clock periods |
| hold | input | 1 | Freeze SCL low at the end of the low phase |
| div_sel | input | DIV_W (1) | Count clock divide select, factor = value + 1 |
| low_lsb | input | CNT_W-1 (8) | Low-phase count, lower bits |
| high_lsb | input | CNT_W-1 (8) | High-phase count, lower bits |
| cnt_ext | input | EXT_W (8) | Extension byte; bit 7 is low count bit 8, bit 6 is high count bit 8 |
| scl_in | input | 1 | Raw SCL line level |
| scl_pull | output | 1 | 1 = drive SCL low |
| rise_stb | output | 1 | One-cycle strobe at the first counted high cycle (sample point) |
| fall_stb | output | 1 | One-cycle strobe at the first low cycle (shift point) |

## Verification
The bench builds the block with its default parameters. Nine-bit counts let the extension bits push a phase past 256 ticks. A one-bit divide select covers both count-clock rates. A two-stage line synchroniser opens a blind window after each release, which a stretched clock has to wait through. A scoreboard compares every measured low length and every sample-to-shift span against values computed from the programmed counts. The cases cover zero counts, external stretching, hold and the stop at the end of a run.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LOW  = 3'd1,
      PH_HOLD = 3'd2,
      PH_RISE = 3'd3,
      PH_HIGH = 3'd4
   } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_hi
);

   generate
      if (STAGES == 0) begin : g_direct
         assign line_hi = line_raw;
      end else begin : g_flops
         logic [STAGES-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '1;
            end else begin
               stage_q[0] <= line_raw;
               for (int k = 1; k < STAGES; k++) begin
                  stage_q[k] <= stage_q[k-1];
               end
            end
         end
         assign line_hi = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scl_count_decode.sv
module scl_count_decode #(
   parameter int CNT_W      = 9,
   parameter int EXT_W      = 8,
   parameter int EXT_LO_BIT = 7,
   parameter int EXT_HI_BIT = 6
) (
   input  logic [CNT_W-2:0] low_lsb,
   input  logic [CNT_W-2:0] high_lsb,
   input  logic [EXT_W-1:0] cnt_ext,
   output logic [CNT_W-1:0] low_eff,
   output logic [CNT_W-1:0] high_eff
);

   localparam int LANES = 2;

   logic [CNT_W-2:0] lsb_arr [LANES];
   logic [CNT_W-1:0] eff_arr [LANES];

   assign lsb_arr[0] = low_lsb;
   assign lsb_arr[1] = high_lsb;

   genvar i;
   generate
      for (i = 0; i < LANES; i++) begin : g_lane
         localparam int MSB_POS = (i == 0) ? EXT_LO_BIT : EXT_HI_BIT;
         logic [CNT_W-1:0] raw;
         assign raw        = {cnt_ext[MSB_POS], lsb_arr[i]};
         // A zero count still gives one tick, so the clock always advances.
         assign eff_arr[i] = (raw == '0) ? CNT_W'(1) : raw;
      end
   endgenerate

   assign low_eff  = eff_arr[0];
   assign high_eff = eff_arr[1];

   // Remaining extension bits belong to other fields and are not used here.
   logic unused_ext_bits;
   assign unused_ext_bits = ^cnt_ext;

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
   parameter int DIV_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             restart,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;

   assign tick = (pre_q == div_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (restart || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   // R7: with a divide factor above one, ticks are never back to back.
   p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && div_sel != '0) |=> (!tick || !$stable(div_sel)));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_gen_pkg::*;
#(
   parameter int CNT_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             line_hi,
   input  logic             tick,
   input  logic [CNT_W-1:0] low_eff,
   input  logic [CNT_W-1:0] high_eff,
   output logic             pull_low,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             restart
);

   localparam logic [CNT_W-1:0] SYNC_N = CNT_W'(SYNC_STAGES);

   phase_e           st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic [CNT_W-1:0] low_last, high_last;
   logic             rise_d, fall_d;

   assign low_last  = low_eff - 1'b1;
   assign high_last = high_eff - 1'b1;

   always_comb begin
      st_n    = st;
      cnt_n   = cnt;
      restart = 1'b0;
      rise_d  = 1'b0;
      fall_d  = 1'b0;
      unique case (st)
         PH_IDLE: begin
            if (run) begin
               st_n    = PH_LOW;
               cnt_n   = '0;
               restart = 1'b1;
               fall_d  = 1'b1;
            end
         end
         PH_LOW: begin
            if (tick) begin
               if (cnt == low_last) begin
                  cnt_n = '0;
                  st_n  = hold ? PH_HOLD : PH_RISE;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
         end
         PH_HOLD: begin
            if (!hold) begin
               st_n  = PH_RISE;
               cnt_n = '0;
            end
         end
         PH_RISE: begin
            // Blind for the synchroniser depth: older samples predate release.
            if (cnt >= SYNC_N) begin
               if (line_hi) begin
                  st_n    = PH_HIGH;
                  cnt_n   = '0;
                  restart = 1'b1;
                  rise_d  = 1'b1;
               end
            end else begin
               cnt_n = cnt + 1'b1;
            end
         end
         PH_HIGH: begin
            if (tick) begin
               if (cnt == high_last) begin
                  cnt_n = '0;
                  if (run) begin
                     st_n    = PH_LOW;
                     restart = 1'b1;
                     fall_d  = 1'b1;
                  end else begin
                     st_n = PH_IDLE;
                  end
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
         end
         default: st_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PH_IDLE;
         cnt      <= '0;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         st       <= st_n;
         cnt      <= cnt_n;
         rise_stb <= rise_d;
         fall_stb <= fall_d;
      end
   end

   assign pull_low = (st == PH_LOW) || (st == PH_HOLD);

   p_fall_in_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> pull_low);
   p_rise_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> !pull_low);
   p_strobes_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));
   p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HOLD && hold) |=> (pull_low && !rise_stb && !fall_stb));
   p_wait_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_RISE && !line_hi) |=> !rise_stb);
   p_eff_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (low_eff != '0) && (high_eff != '0));
   p_low_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_LOW) |-> (cnt < low_eff));
   p_start_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE && run) |=> (pull_low && fall_stb));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
   parameter int CNT_W       = 9,
   parameter int DIV_W       = 1,
   parameter int SYNC_STAGES = 2,
   parameter int EXT_W       = 8,
   parameter int EXT_LO_BIT  = 7,
   parameter int EXT_HI_BIT  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [CNT_W-2:0] low_lsb,
   input  logic [CNT_W-2:0] high_lsb,
   input  logic [EXT_W-1:0] cnt_ext,
   input  logic             scl_in,
   output logic             scl_pull,
   output logic             rise_stb,
   output logic             fall_stb
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         initial $fatal(1, "scl_phase_gen: CNT_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         initial $fatal(1, "scl_phase_gen: DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES >= (1 << (CNT_W - 1))) begin : g_bad_sync
         initial $fatal(1, "scl_phase_gen: SYNC_STAGES out of range");
      end
      if (EXT_LO_BIT >= EXT_W || EXT_HI_BIT >= EXT_W || EXT_LO_BIT == EXT_HI_BIT) begin : g_bad_ext
         initial $fatal(1, "scl_phase_gen: extension bit positions invalid");
      end
   endgenerate

   logic             line_hi;
   logic             tick;
   logic             restart;
   logic [CNT_W-1:0] low_eff;
   logic [CNT_W-1:0] high_eff;

   scl_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (scl_in),
      .line_hi  (line_hi)
   );

   scl_count_decode #(
      .CNT_W      (CNT_W),
      .EXT_W      (EXT_W),
      .EXT_LO_BIT (EXT_LO_BIT),
      .EXT_HI_BIT (EXT_HI_BIT)
   ) u_decode (
      .low_lsb  (low_lsb),
      .high_lsb (high_lsb),
      .cnt_ext  (cnt_ext),
      .low_eff  (low_eff),
      .high_eff (high_eff)
   );

   scl_tick_div #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .restart (restart),
      .tick    (tick)
   );

   scl_phase_fsm #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hold     (hold),
      .line_hi  (line_hi),
      .tick     (tick),
      .low_eff  (low_eff),
      .high_eff (high_eff),
      .pull_low (scl_pull),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .restart  (restart)
   );

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !scl_pull && !$past(scl_pull) && !fall_stb) |=> !fall_stb);

endmodule

// File: tb/scl_phase_gen_test.sv
`timescale 1ns/1ps
module scl_phase_gen_test;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       hold = 1'b0;
   logic [0:0] div_sel = '0;
   logic [7:0] low_lsb = '0;
   logic [7:0] high_lsb = '0;
   logic [7:0] cnt_ext = '0;
   logic       stretch = 1'b0;
   logic       scl_line;
   logic       scl_pull, rise_stb, fall_stb;

   always #4 clk = ~clk;

   assign scl_line = ~scl_pull & ~stretch;

   scl_phase_gen uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hold     (hold),
      .div_sel  (div_sel),
      .low_lsb  (low_lsb),
      .high_lsb (high_lsb),
      .cnt_ext  (cnt_ext),
      .scl_in   (scl_line),
      .scl_pull (scl_pull),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;
   int    q_lo[$];
   int    q_hi[$];
   int    falls = 0;
   int    rises = 0;
   bit    mon_en = 1;
   bit    lo_act = 0;
   bit    hi_act = 0;
   int    lo_n = 0;
   int    hi_n = 0;
   string cur_tag = "R1";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Monitor: measures phases and pops expectations from the scoreboard.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (fall_stb) falls++;
         if (rise_stb) rises++;
         if (fall_stb) chk(scl_pull == 1'b1, "R9 fall strobe in low", scl_pull, 1);
         if (rise_stb) chk(scl_pull == 1'b0, "R9 rise strobe released", scl_pull, 0);
         if (mon_en) begin
            if (fall_stb) begin
               if (hi_act) begin
                  if (q_hi.size() == 0) chk(1'b0, {"R3 unexpected high ", cur_tag}, hi_n, -1);
                  else begin
                     int e;
                     e = q_hi.pop_front();
                     chk(hi_n == e, {"R3 high span ", cur_tag}, hi_n, e);
                  end
                  hi_act = 0;
               end
               lo_act = 1;
               lo_n = 1;
            end else if (lo_act) begin
               if (scl_pull) lo_n++;
               else begin
                  if (q_lo.size() == 0) chk(1'b0, {"R2 unexpected low ", cur_tag}, lo_n, -1);
                  else begin
                     int e;
                     e = q_lo.pop_front();
                     chk(lo_n == e, {"R2 low length ", cur_tag}, lo_n, e);
                  end
                  lo_act = 0;
               end
            end
            if (rise_stb) begin
               hi_act = 1;
               hi_n = 1;
            end else if (hi_act && !fall_stb) begin
               hi_n++;
            end
         end
      end
   end

   // Driver: programs a configuration, pushes expected lengths, runs n periods.
   task automatic run_periods(input int lo, input int hi, input int ext, input int dv,
                              input int n, input int stretch_n, input string tag);
      int el, eh, d, target, f0, r0;
      el = (((ext >> 7) & 1) << 8) + (lo & 255);
      eh = (((ext >> 6) & 1) << 8) + (hi & 255);
      if (el == 0) el = 1;
      if (eh == 0) eh = 1;
      d = dv + 1;
      @(negedge clk);
      low_lsb  = 8'(lo);
      high_lsb = 8'(hi);
      cnt_ext  = 8'(ext);
      div_sel  = 1'(dv);
      cur_tag  = tag;
      for (int i = 0; i < n; i++) q_lo.push_back(el * d);
      for (int i = 0; i < n - 1; i++) q_hi.push_back(eh * d);
      target = falls + n;
      if (stretch_n > 0) stretch = 1'b1;
      run = 1'b1;
      @(posedge clk);
      #2;
      chk(scl_pull && fall_stb, "R11 start edge", {scl_pull, fall_stb}, 3);
      if (stretch_n > 0) begin
         while (scl_pull) begin
            @(posedge clk);
            #2;
         end
         r0 = rises;
         f0 = falls;
         repeat (stretch_n) @(negedge clk);
         chk(rises == r0 && falls == f0 && !scl_pull, "R4 stretched line",
             rises - r0 + falls - f0, 0);
         stretch = 1'b0;
      end
      while (falls < target) @(negedge clk);
      run = 1'b0;
      repeat ((el + eh) * d + SYNC + 8) @(negedge clk);
      chk(!scl_pull, "R10 released after stop", scl_pull, 0);
      f0 = falls + rises;
      repeat (20) @(negedge clk);
      chk(falls + rises == f0 && !scl_pull, "R10 no strobes after stop", falls + rises - f0, 0);
      chk(q_lo.size() == 0, {"R2 all lows seen ", tag}, q_lo.size(), 0);
      chk(q_hi.size() == 0, {"R3 all highs seen ", tag}, q_hi.size(), 0);
      hi_act = 0;
      lo_act = 0;
   endtask

   task automatic hold_case();
      int f0, r0;
      @(negedge clk);
      mon_en   = 0;
      low_lsb  = 8'd6;
      high_lsb = 8'd3;
      cnt_ext  = 8'h00;
      div_sel  = 1'b0;
      hold     = 1'b1;
      run      = 1'b1;
      r0 = rises;
      repeat (3) @(negedge clk);
      f0 = falls;
      repeat (40) @(negedge clk);
      chk(scl_pull == 1'b1, "R8 line held low", scl_pull, 1);
      chk(rises == r0 && falls == f0, "R8 no strobes in hold", rises - r0 + falls - f0, 0);
      hold = 1'b0;
      @(posedge clk);
      #2;
      chk(scl_pull == 1'b0, "R8 release after hold", scl_pull, 0);
      @(negedge clk);
      run = 1'b0;
      repeat (30) @(negedge clk);
      chk(rises == r0 + 1 && !scl_pull, "R8 period finished", rises - r0, 1);
      hi_act = 0;
      lo_act = 0;
      mon_en = 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #2;
      chk(!scl_pull && !rise_stb && !fall_stb, "R1 in reset", {scl_pull, rise_stb, fall_stb}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #2;
      chk(!scl_pull && !rise_stb && !fall_stb, "R1 idle after reset",
          {scl_pull, rise_stb, fall_stb}, 0);
      // R2 R3: basic periods, D = 1
      run_periods(5, 4, 8'h00, 0, 3, 0, "R2");
      // R7: divide by two doubles each phase
      run_periods(3, 2, 8'h00, 1, 3, 0, "R7");
      // R6: zero counts act as one
      run_periods(0, 0, 8'h00, 0, 3, 0, "R6");
      // R5: bit 8 of both counts from the extension byte
      run_periods(2, 1, 8'hC0, 0, 2, 0, "R5");
      // R5: low extension bits ignored
      run_periods(3, 3, 8'h3F, 0, 3, 0, "R5");
      // R3 R4: slave stretching the first high phase
      run_periods(4, 3, 8'h00, 0, 3, 25, "R4");
      // R8: hold at end of low phase
      hold_case();
      // R3: stretch with divide by two
      run_periods(2, 5, 8'h00, 1, 2, 9, "R3");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule